// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block sits between a two-channel converter core and the output pads. Every conversion period it takes one 14-bit sample and one overrange flag from each channel. It re-codes each sample into the selected number format and delays it by a fixed number of conversion periods. It then presents the result on one of three bus arrangements:

- two independent parallel buses;
- one bus that carries channel A and then channel B inside the same period;
- a double-rate arrangement in which each of seven lanes per channel carries an even bit and then the odd bit above it.

The block runs from one fast clock at twice the conversion rate, phase-locked to it. An internal phase bit divides that clock into conversion periods. The first rising edge after reset is released opens period 0, and input samples are captured on every even fast edge counted from there. Coding and bus arrangement are static configuration inputs. An active-low output enable blanks the data and overrange outputs. The data clocks keep running while the outputs are blanked.

Top module: `adc_pair_formatter`

## Requirements
- R1: With `code_sel` = 0 (offset binary), or with the unused value 3, the sample leaves the block unchanged.
- R2: With `code_sel` = 1 (two's complement), the output equals the sample with bit 13 inverted.
- R3: With `code_sel` = 2 (Gray), the output equals s XOR (s >> 1), where s is the offset-binary sample.
- R4: With `bus_mode` = 0 (or the unused value 3), `bus_a` carries channel A and `bus_b` carries channel B. A sample captured on fast edge 2n is shown on fast edges 2(n+16) and 2(n+16)+1, which is 16 conversion periods later.
- R5: With `bus_mode` = 1 (interleaved), `bus_a` shows channel A after the even edge and channel B of the same sample after the odd edge, so channel B lags by 16.5 periods. In this mode `bus_b`, `dclk_b` and `ovr_b_o` stay 0.
- R6: With `bus_mode` = 2 (lane pairs), lane i (bits 6..0) of each bus carries sample bit 2i after the even edge and bit 2i+1 after the odd edge. Bus bits 13..7 stay 0.
- R7: Each overrange flag travels with its own sample through the same delay and is not changed by the coding. In interleaved mode `ovr_a_o` shows flag A and then flag B.
- R8: `dclk_a` is 0 after each even fast edge and 1 after each odd one, so each half-period spans exactly one output word. `dclk_b` equals `dclk_a` outside interleaved mode.
- R9: While `oe_n` is 1 at a fast edge, the data and overrange outputs are 0 after that edge. The data clocks are not affected.
- R10: `code_sel` is taken at the capture edge of each sample. `bus_mode` is taken only at even fast edges, so a change made before an odd edge does not alter the second half of the current word.
- R11: Synchronous reset clears the outputs and flushes the delay line. The first 16 words after reset is released are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the conversion rate |
| rst | input | 1 | Synchronous reset, active high |
| smp_a | input | 14 | Channel A sample, offset binary |
| smp_b | input | 14 | Channel B sample, offset binary |
| ovr_a | input | 1 | Channel A overrange flag |
| ovr_b | input | 1 | Channel B overrange flag |
| code_sel | input | 2 | Output coding: 0 offset, 1 two's complement, 2 Gray |
| bus_mode | input | 2 | 0 split buses, 1 interleaved, 2 lane pairs |
| oe_n | input | 1 | Output enable, active low |
| bus_a | output | 14 | Output bus A |
| bus_b | output | 14 | Output bus B |
| ovr_a_o | output | 1 | Overrange output A |
| ovr_b_o | output | 1 | Overrange output B |
| dclk_a | output | 1 | Data clock for bus A |
| dclk_b | output | 1 | Data clock for bus B |

## Verification
Two things can land on the same fast edge.

- A mode change can meet the second half of an interleaved or lane-pair word. The bench provokes this by changing `bus_mode` just before odd edges. It then judges the result against a reference that takes the mode only at even edges.
- An output-enable toggle can coincide with a word boundary, or with a coding change on the capture edge. The reference applies the enable per fast edge and the coding per captured sample, and every output is compared on every clock.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [1:0] {
        CODE_OFFS = 2'd0,
        CODE_TWOS = 2'd1,
        CODE_GRAY = 2'd2,
        CODE_RSVD = 2'd3
    } code_e;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'd0,
        MODE_ILV   = 2'd1,
        MODE_PAIR  = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    // the unused encoding falls back to split buses
    function automatic logic is_ilv(input logic [1:0] m);
        return m == MODE_ILV;
    endfunction

    function automatic logic is_pair(input logic [1:0] m);
        return m == MODE_PAIR;
    endfunction

endpackage

// File: rtl/fmt_coder.sv
module fmt_coder
    import fmt_pkg::*;
#(
    parameter int W = 14
) (
    input  logic [W-1:0] raw,
    input  logic [1:0]   code,
    output logic [W-1:0] coded
);
    logic [W-1:0] gray;
    logic [W-1:0] twos;

    // Gray: each bit is XOR of itself and its upper neighbour
    assign gray[W-1] = raw[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_gray
        assign gray[i] = raw[i] ^ raw[i+1];
    end

    assign twos = {~raw[W-1], raw[W-2:0]};

    always_comb begin
        case (code)
            CODE_TWOS: coded = twos;
            CODE_GRAY: coded = gray;
            default:   coded = raw;
        endcase
    end
endmodule

// File: rtl/fmt_delay.sv
module fmt_delay #(
    parameter int W     = 30,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_comb stg_d[i] = adv ? din : stg_q[i];
        end else begin : g_body
            always_comb stg_d[i] = adv ? stg_q[i-1] : stg_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) stg_q[i] <= '0;
            else     stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/fmt_lane_mux.sv
module fmt_lane_mux
    import fmt_pkg::*;
#(
    parameter int W = 14   // must be even: lanes carry bit pairs
) (
    input  logic [1:0]   mode,
    input  logic         half,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         oa,
    input  logic         ob,
    output logic [W-1:0] wa,
    output logic [W-1:0] wb,
    output logic         woa,
    output logic         wob,
    output logic         dcb_en
);
    localparam int LANES = W / 2;

    logic [LANES-1:0] pa;
    logic [LANES-1:0] pb;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pa[i] = half ? a[2*i+1] : a[2*i];
        assign pb[i] = half ? b[2*i+1] : b[2*i];
    end

    always_comb begin
        wa     = a;
        wb     = b;
        woa    = oa;
        wob    = ob;
        dcb_en = 1'b1;
        if (is_ilv(mode)) begin
            wa     = half ? b : a;
            wb     = '0;
            woa    = half ? ob : oa;
            wob    = 1'b0;
            dcb_en = 1'b0;
        end else if (is_pair(mode)) begin
            wa = {{(W-LANES){1'b0}}, pa};
            wb = {{(W-LANES){1'b0}}, pb};
        end
    end
endmodule

// File: rtl/adc_pair_formatter.sv
module adc_pair_formatter
    import fmt_pkg::*;
#(
    parameter int SMP_W   = 14,
    parameter int LATENCY = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] smp_a,
    input  logic [SMP_W-1:0] smp_b,
    input  logic             ovr_a,
    input  logic             ovr_b,
    input  logic [1:0]       code_sel,
    input  logic [1:0]       bus_mode,
    input  logic             oe_n,
    output logic [SMP_W-1:0] bus_a,
    output logic [SMP_W-1:0] bus_b,
    output logic             ovr_a_o,
    output logic             ovr_b_o,
    output logic             dclk_a,
    output logic             dclk_b
);
    localparam int PW = 2 * SMP_W + 2;

    typedef struct packed {
        logic             oa;
        logic             ob;
        logic [SMP_W-1:0] a;
        logic [SMP_W-1:0] b;
    } word_t;

    typedef struct packed {
        logic             phase;   // 0: next edge opens a conversion period
        word_t            cur;     // word on the bus in this period
        logic [1:0]       mode;    // arrangement latched at the boundary
        logic [SMP_W-1:0] bus_a;
        logic [SMP_W-1:0] bus_b;
        logic             oa;
        logic             ob;
        logic             dca;
        logic             dcb;
    } st_t;

    st_t s_d, s_q;

    logic             capture;
    logic [SMP_W-1:0] ca, cb;
    word_t            cap_w, pipe_w, src_w;
    logic [PW-1:0]    pipe_raw;
    logic [1:0]       mode_eff;
    logic [SMP_W-1:0] wa, wb;
    logic             woa, wob, dcb_en;

    assign capture = !s_q.phase;

    fmt_coder #(.W(SMP_W)) u_code_a (.raw(smp_a), .code(code_sel), .coded(ca));
    fmt_coder #(.W(SMP_W)) u_code_b (.raw(smp_b), .code(code_sel), .coded(cb));

    assign cap_w = '{oa: ovr_a, ob: ovr_b, a: ca, b: cb};

    fmt_delay #(.W(PW), .DEPTH(LATENCY)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .adv  (capture),
        .din  (cap_w),
        .dout (pipe_raw)
    );
    assign pipe_w = word_t'(pipe_raw);

    assign src_w    = capture ? pipe_w : s_q.cur;
    assign mode_eff = capture ? bus_mode : s_q.mode;

    fmt_lane_mux #(.W(SMP_W)) u_mux (
        .mode   (mode_eff),
        .half   (s_q.phase),
        .a      (src_w.a),
        .b      (src_w.b),
        .oa     (src_w.oa),
        .ob     (src_w.ob),
        .wa     (wa),
        .wb     (wb),
        .woa    (woa),
        .wob    (wob),
        .dcb_en (dcb_en)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = ~s_q.phase;
        if (capture) begin
            s_d.cur  = pipe_w;
            s_d.mode = bus_mode;
        end
        s_d.dca = s_q.phase;
        s_d.dcb = s_q.phase & dcb_en;
        if (oe_n) begin
            s_d.bus_a = '0;
            s_d.bus_b = '0;
            s_d.oa    = 1'b0;
            s_d.ob    = 1'b0;
        end else begin
            s_d.bus_a = wa;
            s_d.bus_b = wb;
            s_d.oa    = woa;
            s_d.ob    = wob;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign bus_a   = s_q.bus_a;
    assign bus_b   = s_q.bus_b;
    assign ovr_a_o = s_q.oa;
    assign ovr_b_o = s_q.ob;
    assign dclk_a  = s_q.dca;
    assign dclk_b  = s_q.dcb;
endmodule

// File: rtl/fmt_chk.sv
module fmt_chk
    import fmt_pkg::*;
#(
    parameter int SMP_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic [SMP_W-1:0] smp_a,
    input logic [SMP_W-1:0] smp_b,
    input logic             ovr_a,
    input logic             ovr_b,
    input logic [1:0]       code_sel,
    input logic [1:0]       bus_mode,
    input logic             oe_n,
    input logic [SMP_W-1:0] bus_a,
    input logic [SMP_W-1:0] bus_b,
    input logic             ovr_a_o,
    input logic             ovr_b_o,
    input logic             dclk_a,
    input logic             dclk_b
);
    localparam int HALF_W = SMP_W / 2;

    logic [1:0] arm_q;
    logic       rst_prev_q;
    logic       seen_q;
    logic [1:0] mode_seen_q;
    logic       unused_ok;

    assign unused_ok = ^{smp_a, smp_b, ovr_a, ovr_b, code_sel};

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst) begin
            arm_q       <= '0;
            seen_q      <= 1'b0;
            mode_seen_q <= '0;
        end else begin
            if (arm_q != 2'd2) arm_q <= arm_q + 2'd1;
            if (dclk_a) begin
                seen_q      <= 1'b1;
                mode_seen_q <= bus_mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_prev_q && !unused_ok && 1'b1) begin
            // R11
            rst_clear_chk: assert (bus_a == '0 && bus_b == '0 && !ovr_a_o
                                   && !ovr_b_o && !dclk_a && !dclk_b);
        end else if (rst_prev_q) begin
            // R11
            rst_clear2_chk: assert (bus_a == '0 && bus_b == '0 && !ovr_a_o
                                    && !ovr_b_o && !dclk_a && !dclk_b);
        end
    end

    // R8
    dclk_toggle_chk: assert property (@(posedge clk) disable iff (rst || arm_q != 2'd2)
        dclk_a != $past(dclk_a));

    // R9
    oe_blank_chk: assert property (@(posedge clk) disable iff (rst || arm_q == 2'd0)
        $past(oe_n) |-> (bus_a == '0 && bus_b == '0 && !ovr_a_o && !ovr_b_o));

    // R5
    ilv_quiet_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
        is_ilv(mode_seen_q) |-> (bus_b == '0 && !dclk_b && !ovr_b_o));

    // R6
    pair_upper_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
        is_pair(mode_seen_q) |-> (bus_a[SMP_W-1:HALF_W] == '0 && bus_b[SMP_W-1:HALF_W] == '0));

    // R8
    dclk_match_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
        !is_ilv(mode_seen_q) |-> (dclk_b == dclk_a));
endmodule

bind adc_pair_formatter fmt_chk #(.SMP_W(SMP_W)) u_chk (.*);

// File: tb/sim_adc_pair_formatter.sv
module sim_adc_pair_formatter;
    localparam int W   = 14;
    localparam int LAT = 16;
    localparam int HN  = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] smp_a = '0, smp_b = '0;
    logic ovr_a = 1'b0, ovr_b = 1'b0, oe_n = 1'b0;
    logic [1:0] code_sel = '0, bus_mode = '0;
    logic [W-1:0] bus_a, bus_b;
    logic ovr_a_o, ovr_b_o, dclk_a, dclk_b;

    always #5 clk = ~clk;

    adc_pair_formatter #(.SMP_W(W), .LATENCY(LAT)) u0 (.*);

    int errs = 0, checks = 0, t = 0;
    string tag = "R11";
    logic [W-1:0] ha [HN], hb [HN];
    logic hoa [HN], hob [HN], ho [HN];
    logic [1:0] hm [HN], hc [HN];

    function automatic logic [W-1:0] enc(input logic [W-1:0] v, input logic [1:0] c);
        if (c == 2'd1) return v ^ (W'(1) << (W - 1));
        if (c == 2'd2) return v ^ (v >> 1);
        return v;
    endfunction

    function automatic logic [W-1:0] lanes(input logic [W-1:0] v, input int h);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W / 2; i++) r[i] = v[2*i+h];
        return r;
    endfunction

    task automatic chk(input string f, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s t=%0d actual=%h expected=%h", tag, f, t, act, exp);
        end
    endtask

    task automatic check_edge(input int te);
        int ev = te - (te % 2), h = te % 2, s = ev - 2 * LAT;
        logic [1:0] m = hm[ev];
        logic [W-1:0] a = '0, b = '0, ea, eb;
        logic oa = 0, ob = 0, eoa, eob, edb;
        if (s >= 0) begin
            a = enc(ha[s], hc[s]); b = enc(hb[s], hc[s]);
            oa = hoa[s]; ob = hob[s];
        end
        ea = a; eb = b; eoa = oa; eob = ob; edb = h[0];
        if (m == 2'd1) begin
            ea = h ? b : a; eb = '0; eoa = h ? ob : oa; eob = 1'b0; edb = 1'b0;
        end else if (m == 2'd2) begin
            ea = lanes(a, h); eb = lanes(b, h);
        end
        if (ho[te]) begin ea = '0; eb = '0; eoa = 0; eob = 0; end
        chk("bus_a", bus_a, ea);
        chk("bus_b", bus_b, eb);
        chk("ovr_a_o", W'(ovr_a_o), W'(eoa));
        chk("ovr_b_o", W'(ovr_b_o), W'(eob));
        chk("dclk_a", W'(dclk_a), W'(h));
        chk("dclk_b", W'(dclk_b), W'(edb));
    endtask

    // drive inputs for edge t, take the edge, check at the next falling edge
    task automatic cyc(input logic [W-1:0] a, input logic [W-1:0] b, input logic oa,
                       input logic ob, input logic [1:0] c, input logic [1:0] m, input logic oe);
        smp_a = a; smp_b = b; ovr_a = oa; ovr_b = ob; code_sel = c; bus_mode = m; oe_n = oe;
        ha[t] = a; hb[t] = b; hoa[t] = oa; hob[t] = ob; hc[t] = c; hm[t] = m; ho[t] = oe;
        @(posedge clk); @(negedge clk);
        check_edge(t);
        t++;
    endtask

    task automatic periods(input int n, input logic [1:0] c, input logic [1:0] m);
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] a = W'($urandom), b = W'($urandom);
            logic oa = 1'($urandom), ob = 1'($urandom);
            cyc(a, b, oa, ob, c, m, 1'b0);
            cyc(a, b, oa, ob, c, m, 1'b0);
        end
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            tag = "R11";
            chk("rst bus_a", bus_a, '0);
            chk("rst bus_b", bus_b, '0);
            chk("rst flags", W'({ovr_a_o, ovr_b_o, dclk_a, dclk_b}), '0);
        end
        rst = 1'b0;
        t = 0;
    endtask

    initial begin
        #2_000_000;
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(4);
        tag = "R1 R4 R8 R11 flush"; periods(LAT + 24, 2'd0, 2'd0);
        tag = "R1 reserved code";   periods(10, 2'd3, 2'd3);
        tag = "R2 twos";            periods(20, 2'd1, 2'd0);
        tag = "R3 gray";            periods(20, 2'd2, 2'd0);
        tag = "R5 R7 interleave";   periods(LAT + 10, 2'd1, 2'd1);
        tag = "R6 lane pairs";      periods(LAT + 10, 2'd2, 2'd2);
        // boundary patterns: all ones, zero, MSB only
        tag = "R3 R6 extremes";
        cyc('1, '0, 1, 0, 2'd2, 2'd2, 0); cyc('1, '0, 1, 0, 2'd2, 2'd2, 0);
        cyc(W'(1) << (W - 1), 1, 0, 1, 2'd1, 2'd2, 0);
        cyc(W'(1) << (W - 1), 1, 0, 1, 2'd1, 2'd2, 0);
        periods(LAT + 2, 2'd0, 2'd2);
        tag = "R9 output enable";
        for (int i = 0; i < 60; i++)
            cyc(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
                2'(i % 3), 2'(i / 7 % 3), 1'((i % 5) == 2 || (i % 7) == 3));
        tag = "R10 mid-word changes";
        for (int i = 0; i < 80; i++) begin
            logic [W-1:0] a = W'($urandom), b = W'($urandom);
            cyc(a, b, 1'($urandom), 1'($urandom), 2'(i % 3), 2'(i % 3), 0);
            cyc(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
                2'($urandom), 2'((i + 1) % 3), 0);
        end
        tag = "R7 overrange";       periods(LAT + 8, 2'd2, 2'd0);
        periods(4, 2'd0, 2'd1);
        do_reset(3);
        tag = "R11 flush after reset"; periods(LAT + 6, 2'd1, 2'd0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule